// File: doc/BRIEF.md
# Configuration Request Header Generator

This block takes one configuration-space access and turns it into a three-doubleword request header plus a data word. The result leaves as 64-bit beats under a valid/ready handshake. A request names a target bus, a device/function, a byte address, an access size of one, two or four bytes, write data and a direction.

The block does the following:
- It picks the type-0 or type-1 format by comparing the target bus with the root bus number it holds.
- It forms byte enables from the size and the low address bits.
- It moves write data into its byte lane.
- It places the data word so that the payload keeps its quadword alignment.

Requests that would reach a device which cannot exist are refused at the door and produce no beats. The block also refuses requests aimed at the root port's own first base address register. A write to the bus-number register of the root device updates the root bus number once that packet has fully left. Only one request is in flight at a time.

Top module: `cfgreq_gen`

## Requirements
- R1: After reset `tx_valid`, `busy` and `req_reject` are low, `req_ready` is high and `root_bus` equals parameter `ROOT_BUS_RST` (default 0x00).
- R2: Header word 0 bits [31:24] hold the format/type code, and the rest of word 0 is 0x000001. The code is 0x04 for a read and 0x44 for a write when the target bus equals `root_bus` (type 0). It is 0x05 for a read and 0x45 for a write otherwise (type 1).
- R3: Header word 1 is {root_bus, 8'h00, tag, byte_enable[7:0]}, with tag 0x1D for reads and 0x10 for writes. Beat 0 carries word 0 in `tx_data[31:0]` and word 1 in `tx_data[63:32]`, with `tx_sop` set and `tx_eop` clear.
- R4: Header word 2 is {target bus, devfn, 16-bit offset}. The offset is the byte address with bits [1:0] cleared. Word 2 always sits in `tx_data[31:0]` of beat 1.
- R5: `req_size` encodes 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. The byte enable field is 0x01 shifted left by address bits [1:0] for one byte. It is 0x03 shifted left by those bits for two bytes, kept to 8 bits. It is 0x0F for four bytes.
- R6: The data word is the write data masked to the access size, then shifted left by 8 × address bits [1:0] and kept to 32 bits. For reads the data word is zero.
- R7: A read, or a write whose address bit 2 is set, is a two-beat packet. Beat 1 is {data word, word 2} with `tx_eop` set.
- R8: A write whose address bit 2 is clear is a three-beat packet. Beat 1 is {0, word 2} with no flags. Beat 2 is {0, data word} with `tx_eop` set.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sop` and `tx_eop` hold. `busy` is high and `req_ready` is low from acceptance until the final beat is taken.
- R10: Consider a write of type 0 whose dword offset is 0x18. When its final beat is accepted, `root_bus` becomes bits [7:0] of the data word. No other event changes `root_bus`.
- R11: A request is refused in three cases. The first is devfn[7:3] nonzero with the target bus equal to `root_bus`. The second is devfn[7:3] nonzero with the target bus equal to `root_bus`+1. The third is a byte address of exactly 0x10 with devfn 0 on `root_bus`.
- R12: A refused request is accepted and `req_reject` pulses high for the cycle after acceptance. No beat is sent, `busy` stays low, and `root_bus` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (bits 7:3) and function (bits 2:0) |
| req_addr | input | ADDR_W | Register byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, right-aligned |
| req_reject | output | 1 | One-cycle pulse: request refused |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Sink takes the beat |
| tx_data | output | 64 | Beat, first word in bits 31:0 |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| busy | output | 1 | A packet is in flight |
| root_bus | output | 8 | Current root bus number |

## Verification
The bench aims at the address cases where beat placement and lanes are easy to mix up. A one-byte write at offset 3 still takes three beats because address bit 2 is clear. A two-byte access at offset 2 gets the 0x0C enable and a 16-bit data shift. A design that tested the whole low three bits, or shifted by the wrong amount, would put the data in the wrong beat or the wrong lane.

The bench moves the root bus number and then checks what follows from it. Type selection, the requester field and the refusal rules must all follow the new value. A design that latched the bus number at the wrong moment would send type-1 to the new root bus. Writes to offset 0x18 on a non-root bus must leave the number alone.

The bench stalls the sink on every other cycle to catch beats that move while held. It also sends a request that sits right next to a refused one, at address 0x14, to catch an over-eager refusal.

// File: rtl/cfgreq_pkg.sv
package cfgreq_pkg;

   // Sequencer position within a packet
   typedef enum logic [1:0] {
      BT_IDLE   = 2'd0,
      BT_FIRST  = 2'd1,
      BT_SECOND = 2'd2,
      BT_THIRD  = 2'd3
   } beat_e;

   // Size codes on req_size
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   // Everything the sequencer needs for one packet
   typedef struct packed {
      logic [31:0] w0;
      logic [31:0] w1;
      logic [31:0] w2;
      logic [31:0] dat;
      logic        three;     // data travels in its own beat
      logic        upd_root;  // packet rewrites the root bus number
   } cfg_pkt_t;

endpackage

// File: rtl/cfgreq_filter.sv
module cfgreq_filter #(
   parameter int ADDR_W   = 12,
   parameter int BAR0_OFS = 'h10
) (
   input  logic [7:0]        root,
   input  logic [7:0]        bus,
   input  logic [7:0]        devfn,
   input  logic [ADDR_W-1:0] addr,
   output logic              type0,
   output logic              reject
);
   localparam logic [ADDR_W-1:0] BAR0_A = ADDR_W'(BAR0_OFS);

   logic dev_nz;
   logic below_root;

   always_comb begin
      type0      = (bus == root);
      below_root = (bus == 8'(root + 8'd1));
      dev_nz     = (devfn[7:3] != 5'd0);
      reject     = (type0 && dev_nz)
                || (below_root && dev_nz)
                || (type0 && (devfn == 8'd0) && (addr == BAR0_A));
   end
endmodule

// File: rtl/cfgreq_hdr.sv
module cfgreq_hdr
   import cfgreq_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int RD_TAG     = 'h1D,
   parameter int WR_TAG     = 'h10,
   parameter int BUSNUM_OFS = 'h18
) (
   input  logic              write,
   input  logic              type0,
   input  logic [7:0]        root,
   input  logic [7:0]        bus,
   input  logic [7:0]        devfn,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [31:0]       wdata,
   output cfg_pkt_t          pkt
);
   localparam logic [ADDR_W-1:0] BUSNUM_A = ADDR_W'(BUSNUM_OFS);

   logic [7:0]  fmt;
   logic [7:0]  tag;
   logic [7:0]  be;
   logic [31:0] mask;
   logic [15:0] ofs;

   always_comb begin
      fmt = {1'b0, write, 3'b000, 1'b1, 1'b0, ~type0};
      tag = write ? 8'(WR_TAG) : 8'(RD_TAG);
      unique case (size)
         SZ_BYTE: begin be = 8'h01 << addr[1:0]; mask = 32'h0000_00FF; end
         SZ_HALF: begin be = 8'h03 << addr[1:0]; mask = 32'h0000_FFFF; end
         default: begin be = 8'h0F;              mask = 32'hFFFF_FFFF; end
      endcase
      ofs      = 16'(addr);
      ofs[1:0] = 2'b00;

      pkt.w0       = {fmt, 8'h00, 16'h0001};
      pkt.w1       = {root, 8'h00, tag, be};
      pkt.w2       = {bus, devfn, ofs};
      pkt.dat      = write ? ((wdata & mask) << {addr[1:0], 3'b000}) : 32'h0;
      pkt.three    = write && !addr[2];
      pkt.upd_root = write && type0 && (addr[ADDR_W-1:2] == BUSNUM_A[ADDR_W-1:2]);
   end
endmodule

// File: rtl/cfgreq_seq.sv
module cfgreq_seq
   import cfgreq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  cfg_pkt_t    pkt_in,
   input  logic        tx_ready,
   output logic        tx_valid,
   output logic [63:0] tx_data,
   output logic        tx_sop,
   output logic        tx_eop,
   output logic        fin
);
   beat_e    st;
   cfg_pkt_t pkt_q;
   logic     take;

   assign take = tx_valid && tx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= BT_IDLE;
         pkt_q <= '0;
      end else begin
         if (load) begin
            st    <= BT_FIRST;
            pkt_q <= pkt_in;
         end else if (take) begin
            unique case (st)
               BT_FIRST:  st <= BT_SECOND;
               BT_SECOND: st <= pkt_q.three ? BT_THIRD : BT_IDLE;
               default:   st <= BT_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      tx_valid = (st != BT_IDLE);
      tx_sop   = 1'b0;
      tx_eop   = 1'b0;
      tx_data  = 64'h0;
      unique case (st)
         BT_FIRST: begin
            tx_data = {pkt_q.w1, pkt_q.w0};
            tx_sop  = 1'b1;
         end
         BT_SECOND: begin
            tx_data = {pkt_q.three ? 32'h0 : pkt_q.dat, pkt_q.w2};
            tx_eop  = !pkt_q.three;
         end
         BT_THIRD: begin
            tx_data = {32'h0, pkt_q.dat};
            tx_eop  = 1'b1;
         end
         default: ;
      endcase
      fin = take && tx_eop;
   end
endmodule

// File: rtl/cfgreq_gen.sv
module cfgreq_gen
   import cfgreq_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int ROOT_BUS_RST = 0,
   parameter int BAR0_OFS     = 'h10,
   parameter int BUSNUM_OFS   = 'h18,
   parameter int RD_TAG       = 'h1D,
   parameter int WR_TAG       = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [7:0]        req_bus,
   input  logic [7:0]        req_devfn,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   output logic              req_reject,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [63:0]       tx_data,
   output logic              tx_sop,
   output logic              tx_eop,
   output logic              busy,
   output logic [7:0]        root_bus
);
   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr_w
         $error("cfgreq_gen: ADDR_W must lie in 8..16");
      end
      if (ROOT_BUS_RST < 0 || ROOT_BUS_RST > 255) begin : g_bad_root
         $error("cfgreq_gen: ROOT_BUS_RST must fit in 8 bits");
      end
      if (BAR0_OFS >= (1 << ADDR_W) || BUSNUM_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
         $error("cfgreq_gen: register offsets exceed the address width");
      end
   endgenerate

   logic     accept;
   logic     type0;
   logic     refuse;
   logic     fin;
   logic     upd_q;
   logic [7:0] new_root_q;
   cfg_pkt_t pkt;

   assign busy      = tx_valid;
   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;

   cfgreq_filter #(.ADDR_W(ADDR_W), .BAR0_OFS(BAR0_OFS)) u_filter (
      .root   (root_bus),
      .bus    (req_bus),
      .devfn  (req_devfn),
      .addr   (req_addr),
      .type0  (type0),
      .reject (refuse)
   );

   cfgreq_hdr #(.ADDR_W(ADDR_W), .RD_TAG(RD_TAG), .WR_TAG(WR_TAG),
                .BUSNUM_OFS(BUSNUM_OFS)) u_hdr (
      .write (req_write),
      .type0 (type0),
      .root  (root_bus),
      .bus   (req_bus),
      .devfn (req_devfn),
      .addr  (req_addr),
      .size  (req_size),
      .wdata (req_wdata),
      .pkt   (pkt)
   );

   cfgreq_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && !refuse),
      .pkt_in   (pkt),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_sop   (tx_sop),
      .tx_eop   (tx_eop),
      .fin      (fin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_reject <= 1'b0;
         upd_q      <= 1'b0;
         new_root_q <= 8'h00;
         root_bus   <= 8'(ROOT_BUS_RST);
      end else begin
         req_reject <= accept && refuse;
         if (accept && !refuse) begin
            upd_q      <= pkt.upd_root;
            new_root_q <= pkt.dat[7:0];
         end
         if (fin && upd_q) root_bus <= new_root_q;
      end
   end
endmodule

// File: rtl/cfgreq_gen_chk.sv
module cfgreq_gen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        req_reject,
   input logic        tx_valid,
   input logic        tx_ready,
   input logic [63:0] tx_data,
   input logic        tx_sop,
   input logic        tx_eop,
   input logic        busy,
   input logic [7:0]  root_bus
);
   // R9: a stalled beat holds
   assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)
                                   && $stable(tx_sop) && $stable(tx_eop)));

   // R9: once the final beat is taken the block is free again
   assert_free_after_eop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_eop) |=> (!busy && req_ready));

   // R7 / R8: no beat is both first and last
   assert_sop_eop_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !(tx_sop && tx_eop));

   // R12: an accepted request either starts a packet or is refused
   assert_accept_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> ((tx_valid && tx_sop) != req_reject));

   // R12: a refusal sends nothing
   assert_reject_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
      req_reject |-> (!tx_valid && !busy));

   // R10: root bus moves only right after a final beat is taken
   assert_root_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(root_bus) |-> $past(tx_valid && tx_ready && tx_eop));
endmodule

bind cfgreq_gen cfgreq_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_reject (req_reject),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_data    (tx_data),
   .tx_sop     (tx_sop),
   .tx_eop     (tx_eop),
   .busy       (busy),
   .root_bus   (root_bus)
);

// File: tb/cfgreq_gen_tb.sv
`timescale 1ns/1ps
module cfgreq_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = 8'h00;
   logic [7:0]  req_devfn = 8'h00;
   logic [11:0] req_addr = 12'h000;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_wdata = 32'h0;
   logic        req_reject;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [63:0] tx_data;
   logic        tx_sop;
   logic        tx_eop;
   logic        busy;
   logic [7:0]  root_bus;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_root = 8'h00;

   always #2 clk = ~clk;

   cfgreq_gen u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_reject(req_reject), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .busy(busy),
      .root_bus(root_bus)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // One request, expectations computed from the requirements
   task automatic do_req(input bit wr, input logic [7:0] bus, input logic [7:0] devfn,
                         input logic [11:0] addr, input logic [1:0] sz,
                         input logic [31:0] wd, input bit stall, input string name);
      bit t0, rej, three, upd;
      logic [7:0] fmt, tag, be;
      logic [31:0] msk, dat, w0, w1, w2;
      logic [63:0] eb [3];
      bit es [3];
      bit ee [3];
      int n;
      int nb;
      bit held_v;
      logic [63:0] held;
      string fr;

      t0  = (bus == exp_root);
      rej = (t0 && devfn[7:3] != 0) || ((bus == 8'(exp_root + 1)) && devfn[7:3] != 0)
         || (t0 && devfn == 0 && addr == 12'h010);
      fmt = wr ? (t0 ? 8'h44 : 8'h45) : (t0 ? 8'h04 : 8'h05);
      tag = wr ? 8'h10 : 8'h1D;
      case (sz)
         2'd0: begin be = 8'(1 << addr[1:0]); msk = 32'hFF; end
         2'd1: begin be = 8'(3 << addr[1:0]); msk = 32'hFFFF; end
         default: begin be = 8'h0F; msk = 32'hFFFF_FFFF; end
      endcase
      dat = wr ? 32'((wd & msk) << (8 * addr[1:0])) : 32'h0;
      w0 = {fmt, 24'h000001};
      w1 = {exp_root, 8'h00, tag, be};
      w2 = {bus, devfn, 4'h0, addr[11:2], 2'b00};
      three = wr && (addr[2] == 1'b0);
      upd = wr && t0 && (addr[11:2] == 10'h006);
      fr = three ? "R8" : "R7";
      eb[0] = {w1, w0}; es[0] = 1; ee[0] = 0;
      if (three) begin
         eb[1] = {32'h0, w2}; es[1] = 0; ee[1] = 0;
         eb[2] = {32'h0, dat}; es[2] = 0; ee[2] = 1;
         n = 3;
      end else begin
         eb[1] = {dat, w2}; es[1] = 0; ee[1] = 1;
         eb[2] = '0; es[2] = 0; ee[2] = 0;
         n = 2;
      end

      @(negedge clk);
      req_write = wr; req_bus = bus; req_devfn = devfn; req_addr = addr;
      req_size = sz; req_wdata = wd; req_valid = 1'b1;
      chk(req_ready == 1'b1, "R9", {name, " ready before request"}, 64'(req_ready), 64'h1);
      @(negedge clk);
      req_valid = 1'b0;
      if (rej) begin
         chk(req_reject == 1'b1, "R11", {name, " refused"}, 64'(req_reject), 64'h1);
         chk(!tx_valid && !busy, "R12", {name, " nothing sent"},
             64'({tx_valid, busy}), 64'h0);
         @(negedge clk);
         chk(req_reject == 1'b0 && !tx_valid, "R12", {name, " pulse ends"},
             64'({req_reject, tx_valid}), 64'h0);
         chk(root_bus == exp_root, "R12", {name, " root kept"}, 64'(root_bus), 64'(exp_root));
         return;
      end
      chk(req_reject == 1'b0, "R11", {name, " not refused"}, 64'(req_reject), 64'h0);
      nb = 0; held_v = 0; held = '0;
      for (int cyc = 0; cyc < 12 && nb < n; cyc++) begin
         bit rdy;
         rdy = !(stall && (cyc % 2 == 0));
         chk(tx_valid && busy && !req_ready, "R9", {name, " busy during packet"},
             64'({tx_valid, busy, req_ready}), 64'h6);
         if (held_v)
            chk(tx_data == held, "R9", {name, " held beat"}, tx_data, held);
         tx_ready = rdy;
         if (rdy) begin
            if (nb == 0) begin
               chk(tx_data == eb[0], "R3", {name, " beat 0"}, tx_data, eb[0]);
               chk(tx_data[31:24] == fmt, "R2", {name, " fmt code"}, 64'(tx_data[31:24]), 64'(fmt));
               chk(tx_data[39:32] == be, "R5", {name, " byte enables"}, 64'(tx_data[39:32]), 64'(be));
            end else if (nb == 1) begin
               chk(tx_data[31:0] == w2, "R4", {name, " word 2"}, 64'(tx_data[31:0]), 64'(w2));
               chk(tx_data == eb[1], three ? "R8" : "R6", {name, " beat 1"}, tx_data, eb[1]);
            end else begin
               chk(tx_data == eb[2], "R6", {name, " beat 2"}, tx_data, eb[2]);
            end
            chk(tx_sop == es[nb] && tx_eop == ee[nb], fr, {name, " flags"},
                64'({tx_sop, tx_eop}), 64'({es[nb], ee[nb]}));
            nb++;
            held_v = 0;
         end else begin
            held = tx_data;
            held_v = 1;
         end
         @(negedge clk);
      end
      tx_ready = 1'b0;
      chk(nb == n, fr, {name, " beat count"}, 64'(nb), 64'(n));
      chk(!tx_valid && !busy && req_ready, "R9", {name, " idle after eop"},
          64'({tx_valid, busy, req_ready}), 64'h1);
      if (upd) exp_root = dat[7:0];
      chk(root_bus == exp_root, "R10", {name, " root bus"}, 64'(root_bus), 64'(exp_root));
   endtask

   task automatic t_reset();
      chk(!tx_valid && !busy && !req_reject && req_ready, "R1", "reset outputs",
          64'({tx_valid, busy, req_reject, req_ready}), 64'h1);
      chk(root_bus == 8'h00, "R1", "reset root bus", 64'(root_bus), 64'h0);
   endtask

   task automatic t_reads();
      do_req(0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 0, "rd type0 word");
      do_req(0, 8'h03, 8'h08, 12'h0A6, 2'd0, 32'h0, 1, "rd type1 byte");
      do_req(0, 8'h00, 8'h00, 12'h014, 2'd1, 32'h0, 0, "rd beside bar0");
   endtask

   task automatic t_writes();
      do_req(1, 8'h02, 8'h00, 12'h00E, 2'd1, 32'hCAFE_1234, 1, "wr half off2 two-beat");
      do_req(1, 8'h00, 8'h00, 12'h020, 2'd2, 32'hDEAD_BEEF, 1, "wr word aligned");
      do_req(1, 8'h01, 8'h00, 12'h013, 2'd0, 32'h1234_56A5, 0, "wr byte off3 three-beat");
      do_req(1, 8'h04, 8'h11, 12'h104, 2'd3, 32'h0BAD_F00D, 0, "wr word unaligned");
   endtask

   task automatic t_refuse();
      do_req(0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0, 0, "root dev1");
      do_req(1, 8'h01, 8'h10, 12'h004, 2'd2, 32'h5, 0, "below root dev2");
      do_req(0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 0, "root bar0");
      do_req(0, 8'h00, 8'h00, 12'h008, 2'd2, 32'h0, 0, "after refusals");
   endtask

   task automatic t_root_move();
      do_req(1, 8'h05, 8'h00, 12'h018, 2'd2, 32'h0000_0A09, 0, "busnum wr non-root");
      do_req(1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h0006_0A05, 1, "busnum wr root");
      do_req(0, 8'h05, 8'h00, 12'h000, 2'd2, 32'h0, 0, "rd new root");
      do_req(0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 0, "rd old root");
      do_req(0, 8'h06, 8'h18, 12'h000, 2'd2, 32'h0, 0, "below new root dev3");
      do_req(0, 8'h05, 8'h00, 12'h010, 2'd2, 32'h0, 0, "new root bar0");
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reads();
      t_writes();
      t_refuse();
      t_root_move();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule